// File: doc/BRIEF.md
# DMA channel event interrupt unit

This block holds the event and interrupt logic of one DMA channel. It counts elements within each frame and frames within each block of a transfer, and it turns that progress into four status events: half-frame, start of the last frame, end of frame and end of block. It also turns pulses from the channel's ports into two error events: a time-out on the source or destination side, and a synchronization request dropped because an earlier one is still pending.

Software programs an enable mask through a small register port. An event whose enable is set records a sticky status bit. Any set status bit holds the single interrupt line high until software reads the status register, and that read clears the register. An event whose enable is clear leaves no trace. The element count per frame and the frame count per block come in as configuration inputs. A block starts with a start strobe, and each element moved is reported with a one-cycle strobe.

Top module: `dma_chan_irq`

## Requirements
- R1: Register address 0 is the enable mask, and address 1 is the status register. In both, bit 0 is time-out, bit 1 is sync-drop, bit 2 is half-frame, bit 3 is last-frame start, bit 4 is end-of-frame and bit 5 is end-of-block. Bits 15:6 always read 0. After reset the enable mask reads 0x0003 and the status register reads 0. Writes to address 1 are ignored.
- R2: Status bits are sticky. A read of address 1 returns the current value and clears the register at that clock edge. An enabled event that arrives in the same cycle as the read is kept and is visible after the read.
- R3: An enabled event sets its status bit at the clock edge that samples the event. `irq` is high whenever any status bit is set.
- R4: An event whose enable bit is 0 sets no status bit and raises no interrupt.
- R5: A time-out pulse on `src_tout` or on `dst_tout` is a time-out event (bit 0).
- R6: `sync_req` while `sync_pending` is high is a sync-drop event (bit 1). `sync_req` alone is not an event.
- R7: Half-frame fires on the element that brings the count within the current frame to floor(N/2), where N is `cfg_elems`. If floor(N/2) is 0, it fires on element 1.
- R8: End-of-frame fires on the Nth element of each frame. End-of-block fires together with it on the last frame. After end-of-block the channel is idle and ignores `elem_done` until the next `blk_start`.
- R9: Last-frame fires on the end-of-frame of the second-to-last frame. When `cfg_frames` is 1, it fires on `blk_start`.
- R10: `blk_start` restarts the element and frame counts at zero, even in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Begin a block transfer |
| elem_done | input | 1 | One element moved |
| cfg_elems | input | ELEM_W | Elements per frame (at least 1) |
| cfg_frames | input | FRAME_W | Frames per block (at least 1) |
| src_tout | input | 1 | Source port time-out pulse |
| dst_tout | input | 1 | Destination port time-out pulse |
| sync_req | input | 1 | New synchronization request |
| sync_pending | input | 1 | A previous request is still pending |
| reg_addr | input | 1 | 0 selects enable, 1 selects status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when reg_addr is 1) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data |
| irq | output | 1 | Interrupt to the processor |

## Verification
The coincidence that matters is a status read landing in the same cycle as a new event. The clear and the set then hit the same register bits at one edge.

The bench leaves a sync-drop bit standing. It then pulses a source time-out in the very cycle that reads status. It expects the read to return only the old bit, and the next read to return only the time-out bit with `irq` still high.

Other same-cycle groupings come from the counters themselves: end-of-frame with last-frame, end-of-frame with end-of-block, and half-frame with end-of-frame when a frame has one element. The bench sweeps element and frame counts so that every one of these groupings appears and is compared against an arithmetic model.

// File: rtl/dma_chan_irq.sv
module dma_chan_irq #(
  parameter int ELEM_W  = 8,
  parameter int FRAME_W = 8,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_start,
  input  logic               elem_done,
  input  logic [ELEM_W-1:0]  cfg_elems,
  input  logic [FRAME_W-1:0] cfg_frames,
  input  logic               src_tout,
  input  logic               dst_tout,
  input  logic               sync_req,
  input  logic               sync_pending,
  input  logic               reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq
);
  localparam int NEV = 6;

  logic [NEV-1:0]     en_q, stat_q;
  logic [ELEM_W-1:0]  ecnt;
  logic [FRAME_W-1:0] fcnt;
  logic               busy;

  wire               step  = busy & elem_done;
  wire [ELEM_W-1:0]  enext = ecnt + 1'b1;
  wire [ELEM_W-1:0]  hhalf = cfg_elems >> 1;
  wire [ELEM_W-1:0]  hpt   = (hhalf == '0) ? ELEM_W'(1) : hhalf;
  wire [FRAME_W-1:0] flast = cfg_frames - 1'b1;
  wire [FRAME_W-1:0] fnext = fcnt + 1'b1;

  wire ev_eof  = step & (enext == cfg_elems);
  wire ev_eob  = ev_eof & (fcnt == flast);
  wire ev_half = step & (enext == hpt);
  wire ev_last = (ev_eof & ~ev_eob & (fnext == flast)) |
                 (blk_start & (cfg_frames == FRAME_W'(1)));
  wire ev_tout = src_tout | dst_tout;
  wire ev_drop = sync_req & sync_pending;

  wire [NEV-1:0] ev  = {ev_eob, ev_eof, ev_last, ev_half, ev_drop, ev_tout};
  wire [NEV-1:0] rec = ev & en_q;
  wire           clr = reg_rd & reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      fcnt <= '0;
      busy <= 1'b0;
    end else if (blk_start) begin
      ecnt <= '0;
      fcnt <= '0;
      busy <= 1'b1;
    end else if (step) begin
      if (ev_eof) begin
        ecnt <= '0;
        if (ev_eob) busy <= 1'b0;
        else        fcnt <= fnext;
      end else begin
        ecnt <= enext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= NEV'(6'b000011);
      stat_q <= '0;
    end else begin
      if (reg_wr && !reg_addr) en_q <= reg_wdata[NEV-1:0];
      stat_q <= (clr ? '0 : stat_q) | rec;
    end
  end

  assign reg_rdata = {{(REG_W-NEV){1'b0}}, (reg_addr ? stat_q : en_q)};
  assign irq       = |stat_q;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[REG_W-1:NEV];

  AST_NO_UNENABLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0)); // R4
  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|rec) |=> irq); // R3
  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && rec == '0) |=> (stat_q == '0)); // R2
  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> (en_q == $past(reg_wdata[NEV-1:0]))); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NEV] == '0); // R1
  AST_IDLE_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eob && !blk_start) |=> !busy); // R8
endmodule

// File: tb/tb_dma_chan_irq.sv
`timescale 1ns/1ps
module tb_dma_chan_irq;
  localparam int EW = 4, FW = 3, RW = 16;

  logic clk = 0, rst_n = 0;
  logic blk_start = 0, elem_done = 0, src_tout = 0, dst_tout = 0;
  logic sync_req = 0, sync_pending = 0, reg_addr = 0, reg_wr = 0, reg_rd = 0;
  logic [EW-1:0] cfg_elems = 1;
  logic [FW-1:0] cfg_frames = 1;
  logic [RW-1:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;

  dma_chan_irq #(.ELEM_W(EW), .FRAME_W(FW), .REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .elem_done(elem_done),
    .cfg_elems(cfg_elems), .cfg_frames(cfg_frames), .src_tout(src_tout),
    .dst_tout(dst_tout), .sync_req(sync_req), .sync_pending(sync_pending),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [RW-1:0] got, input logic [RW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [RW-1:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic wr(input logic a, input logic [RW-1:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic pulse_start;
    @(negedge clk); blk_start = 1; @(posedge clk); #1 blk_start = 0;
  endtask

  task automatic pulse_elem;
    @(negedge clk); elem_done = 1; @(posedge clk); #1 elem_done = 0;
  endtask

  task automatic expect_stat(input string req, input logic [5:0] exp);
    logic [RW-1:0] v;
    @(negedge clk); #0.5 check({req, " irq"}, RW'(irq), RW'(exp != 0));
    rd(1'b1, v);
    check(req, v, RW'(exp));
  endtask

  function automatic logic [5:0] model(int i, int n, int f, int nf);
    int h; logic eof, eob, lst, hf;
    h   = (n / 2 == 0) ? 1 : n / 2;
    hf  = (i == h);
    eof = (i == n);
    eob = eof && (f == nf - 1);
    lst = eof && !eob && (f + 1 == nf - 1);
    return {eob, eof, lst, hf, 1'b0, 1'b0};
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(1'b0, v); check("R1 enable reset", v, 16'h0003);
    rd(1'b1, v); check("R1 status reset", v, 16'h0000);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); check("R1 status write ignored", v, 16'h0000);
    wr(1'b0, 16'hFFFF);
    rd(1'b0, v); check("R1 reserved bits", v, 16'h003F);

    @(negedge clk); src_tout = 1; @(posedge clk); #1 src_tout = 0;
    expect_stat("R5 src time-out", 6'b000001);
    @(negedge clk); dst_tout = 1; @(posedge clk); #1 dst_tout = 0;
    expect_stat("R5 dst time-out", 6'b000001);
    @(negedge clk); sync_req = 1; @(posedge clk); #1 sync_req = 0;
    expect_stat("R6 request alone", 6'b000000);
    @(negedge clk); sync_req = 1; sync_pending = 1; @(posedge clk); #1 sync_req = 0; sync_pending = 0;
    expect_stat("R6 sync drop", 6'b000010);

    @(negedge clk); sync_req = 1; sync_pending = 1; @(posedge clk); #1 sync_req = 0; sync_pending = 0;
    @(negedge clk); src_tout = 1; reg_addr = 1; reg_rd = 1; #1 v = reg_rdata;
    @(posedge clk); #1 src_tout = 0; reg_rd = 0;
    check("R2 read before clear", v, 16'h0002);
    expect_stat("R2 event kept across clear", 6'b000001);
    expect_stat("R2 cleared after read", 6'b000000);

    for (int n = 1; n <= 6; n++) begin
      for (int nf = 1; nf <= 3; nf++) begin
        cfg_elems = EW'(n); cfg_frames = FW'(nf);
        pulse_start;
        expect_stat("R9 start of block", {1'b0, 1'b0, (nf == 1), 3'b000});
        for (int f = 0; f < nf; f++)
          for (int i = 1; i <= n; i++) begin
            pulse_elem;
            expect_stat("R7 R8 R9 progress", model(i, n, f, nf));
          end
        pulse_elem;
        expect_stat("R8 idle after block", 6'b000000);
      end
    end

    cfg_elems = 4; cfg_frames = 2;
    pulse_start; expect_stat("R10 start", 6'b000000);
    pulse_elem; pulse_elem; expect_stat("R10 partial", 6'b000100);
    pulse_start; expect_stat("R10 restart", 6'b000000);
    pulse_elem; expect_stat("R10 count restarted", 6'b000000);
    pulse_elem; expect_stat("R10 half after restart", 6'b000100);

    cfg_elems = 2; cfg_frames = 2;
    for (int e = 0; e < 64; e++) begin
      wr(1'b0, RW'(e));
      pulse_start; expect_stat("R3 R4 mask start", 6'b000000);
      pulse_elem; expect_stat("R3 R4 mask half", 6'b000100 & 6'(e));
      pulse_elem; expect_stat("R3 R4 mask eof+last", 6'b011000 & 6'(e));
      pulse_elem; expect_stat("R3 R4 mask half 2", 6'b000100 & 6'(e));
      pulse_elem; expect_stat("R3 R4 mask eof+eob", 6'b110000 & 6'(e));
      @(negedge clk); src_tout = 1; sync_req = 1; sync_pending = 1;
      @(posedge clk); #1 src_tout = 0; sync_req = 0; sync_pending = 0;
      expect_stat("R3 R4 mask errors", 6'b000011 & 6'(e));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule